// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Engine

This engine follows a chain of descriptors held in memory and sends the buffers they point at out on a valid/ready byte stream. A neighbouring register block writes a starting descriptor pointer while the engine rests. Then, with the channel running, it strobes a tail pointer. The engine fetches each descriptor through a single word-wide memory port with a request/acknowledge handshake. It streams the buffer bytes out one 32-bit word per beat. It then writes a completion status back into the descriptor and moves on through the next-descriptor link.

Start-of-frame and end-of-frame flags in each descriptor group one or more buffers into a packet. The start-of-frame descriptor also supplies a set of application words, which are held on a side output for the whole packet. The walk ends after the descriptor at the tail address has been processed, or earlier at a descriptor that is already marked complete. A packet that would grow past the assembly limit stops the engine with a sticky error flag.

Pointers are byte addresses. Buffers are word aligned. Only the low word of each 64-bit pointer field is used.

Top module: `sg_mm2s_engine`

## Requirements
- R1: After reset, idle_o is 1, err_o is 0, done_o is 0, m_tvalid_o is 0 and cur_ptr_o is 0.
- R2: While the engine rests, a tail_wr_i pulse with run_i high and no error starts a walk at cur_ptr_o and drops idle_o. A tail_wr_i pulse with run_i low leaves idle_o at 1 and makes no memory access. cur_load_i loads cur_ptr_i only while the engine rests.
- R3: The descriptor at address A is read as follows: next pointer at A+0x00, buffer address at A+0x08, control at A+0x18, status at A+0x1C, and application word k at A+0x20+4k. Control bits 22:0 give the length in bytes, bit 27 is start of frame and bit 26 is end of frame. Status bit 31 is the complete flag.
- R4: If a fetched status already has bit 31 set, the engine raises idle_o and stops. It moves no data, writes nothing back and leaves cur_ptr_o at that descriptor.
- R5: Buffer bytes leave in address order, one memory word per beat, with the byte at the lowest address in m_tdata_o[7:0]. m_tkeep_o is 4'hF on every beat except the last beat of a descriptor, where only its low (length mod 4) bits are set, or all four bits when the length is a multiple of 4. A zero-length descriptor without end of frame sends no beat.
- R6: m_tlast_o is 1 only on the final beat of an end-of-frame descriptor. A zero-length end-of-frame descriptor sends a single beat with m_tkeep_o equal to 0 and m_tlast_o equal to 1.
- R7: After a descriptor's data has been sent, its status word is written as length | 0x8000_0000.
- R8: done_o pulses for exactly one cycle for each end-of-frame descriptor that is written back.
- R9: After write-back, cur_ptr_o takes the next pointer. If the descriptor just written was at the tail address, idle_o rises and the walk ends. Otherwise the next descriptor is fetched.
- R10: A start-of-frame descriptor restarts the packet byte count and puts its application words on app_o, with word k at bits 32k+31:32k. app_o keeps them until the next start-of-frame descriptor.
- R11: A descriptor that would bring the packet past MAX_PKT_BYTES (16384 by default) sets err_o and idle_o. It moves no data and has no write-back, and cur_ptr_o stays on it. A packet of exactly MAX_PKT_BYTES is accepted. err_o holds until reset, and later tail strobes start nothing.
- R12: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o, m_tdata_o, m_tkeep_o and m_tlast_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel running |
| cur_load_i | input | 1 | Load the current descriptor pointer |
| cur_ptr_i | input | AW | Pointer value for cur_load_i |
| tail_wr_i | input | 1 | Tail pointer strobe |
| tail_ptr_i | input | AW | Tail descriptor address |
| idle_o | output | 1 | Engine at rest |
| err_o | output | 1 | Sticky packet-size error |
| done_o | output | 1 | One-cycle packet completion pulse |
| cur_ptr_o | output | AW | Current descriptor pointer |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 32 | Stream data |
| m_tkeep_o | output | 4 | Byte enables |
| m_tlast_o | output | 1 | Final beat of packet |
| app_o | output | APP_WORDS*32 | Application words of the current packet |

## Verification
The assertions assume a memory that acknowledges each request once, and does so before the request changes. They also assume that tail and current-pointer strobes are single-cycle pulses, and that software does not rewrite descriptors while a walk is running. The bench's memory model acknowledges one cycle after it sees a request, then drops the acknowledge for a cycle. The bench writes descriptors and issues pointer loads only while idle_o is high. The stream sink drops m_tready_i on a pseudo-random pattern, so the hold property sees real backpressure.

// File: rtl/sg_mm2s_pkg.sv
package sg_mm2s_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_APP,
        S_RD,
        S_BEAT,
        S_WB
    } sg_state_e;

    localparam int CTRL_EOF_BIT  = 26;
    localparam int CTRL_SOF_BIT  = 27;
    localparam int STAT_DONE_BIT = 31;

    localparam logic [7:0] OFF_NEXT = 8'h00;
    localparam logic [7:0] OFF_BUF  = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h18;
    localparam logic [7:0] OFF_STAT = 8'h1C;
    localparam logic [7:0] OFF_APP  = 8'h20;
endpackage

// File: rtl/sg_keep_gen.sv
module sg_keep_gen #(
    parameter int LEN_W = 23
) (
    input  logic [LEN_W-1:0] rem_i,
    input  logic             eof_i,
    output logic [3:0]       keep_o,
    output logic             last_o,
    output logic [2:0]       step_o
);
    logic full;
    assign full   = rem_i >= LEN_W'(4);
    assign step_o = full ? 3'd4 : rem_i[2:0];
    assign last_o = eof_i && (rem_i <= LEN_W'(4));

    for (genvar i = 0; i < 4; i++) begin : g_keep
        assign keep_o[i] = rem_i > LEN_W'(i);
    end
endmodule

// File: rtl/sg_pkt_limit.sv
module sg_pkt_limit #(
    parameter int LEN_W = 23,
    parameter int POS_W = 15,
    parameter int MAX_BYTES = 16384
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             sof_i,
    output logic             over_o,
    output logic [POS_W-1:0] pos_nxt_o
);
    localparam int SUM_W = ((LEN_W > POS_W) ? LEN_W : POS_W) + 1;

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;

    assign base      = sof_i ? '0 : SUM_W'(pos_i);
    assign sum       = base + SUM_W'(len_i);
    assign over_o    = sum > SUM_W'(MAX_BYTES);
    assign pos_nxt_o = sum[POS_W-1:0];
endmodule

// File: rtl/sg_mm2s_engine.sv
module sg_mm2s_engine #(
    parameter int AW            = 32,
    parameter int LEN_W         = 23,
    parameter int APP_WORDS     = 6,
    parameter int MAX_PKT_BYTES = 16384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    cur_load_i,
    input  logic [AW-1:0]           cur_ptr_i,
    input  logic                    tail_wr_i,
    input  logic [AW-1:0]           tail_ptr_i,
    output logic                    idle_o,
    output logic                    err_o,
    output logic                    done_o,
    output logic [AW-1:0]           cur_ptr_o,
    output logic                    mem_req_o,
    output logic                    mem_we_o,
    output logic [AW-1:0]           mem_addr_o,
    output logic [31:0]             mem_wdata_o,
    input  logic                    mem_ack_i,
    input  logic [31:0]             mem_rdata_i,
    output logic                    m_tvalid_o,
    input  logic                    m_tready_i,
    output logic [31:0]             m_tdata_o,
    output logic [3:0]              m_tkeep_o,
    output logic                    m_tlast_o,
    output logic [APP_WORDS*32-1:0] app_o
);
    import sg_mm2s_pkg::*;

    localparam int POS_W  = $clog2(MAX_PKT_BYTES + 1);
    localparam int AIDX_W = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;

    typedef struct packed {
        sg_state_e                   st;
        logic                        idle;
        logic                        err;
        logic                        done;
        logic [AW-1:0]               cur;
        logic [AW-1:0]               tail;
        logic [AW-1:0]               nxt;
        logic [AW-1:0]               bptr;
        logic [31:0]                 ctrl;
        logic [LEN_W-1:0]            rem;
        logic [POS_W-1:0]            pos;
        logic [1:0]                  widx;
        logic [AIDX_W-1:0]           aidx;
        logic [31:0]                 beat;
        logic [APP_WORDS-1:0][31:0]  app;
    } regs_t;

    regs_t r_q, r_d;

    logic [LEN_W-1:0] len;
    logic             sof, eof;
    logic [3:0]       keep;
    logic             last;
    logic [2:0]       step;
    logic             over;
    logic [POS_W-1:0] pos_nxt;
    logic             go_data;
    logic [7:0]       fetch_off;

    assign len = r_q.ctrl[LEN_W-1:0];
    assign sof = r_q.ctrl[CTRL_SOF_BIT];
    assign eof = r_q.ctrl[CTRL_EOF_BIT];

    sg_keep_gen #(.LEN_W(LEN_W)) u_keep (
        .rem_i (r_q.rem),
        .eof_i (eof),
        .keep_o(keep),
        .last_o(last),
        .step_o(step)
    );

    sg_pkt_limit #(.LEN_W(LEN_W), .POS_W(POS_W), .MAX_BYTES(MAX_PKT_BYTES)) u_limit (
        .pos_i    (r_q.pos),
        .len_i    (len),
        .sof_i    (sof),
        .over_o   (over),
        .pos_nxt_o(pos_nxt)
    );

    always_comb begin
        case (r_q.widx)
            2'd0:    fetch_off = OFF_NEXT;
            2'd1:    fetch_off = OFF_BUF;
            2'd2:    fetch_off = OFF_CTRL;
            default: fetch_off = OFF_STAT;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        go_data  = 1'b0;
        if (tail_wr_i) r_d.tail = tail_ptr_i;

        case (r_q.st)
            S_IDLE: begin
                if (tail_wr_i && run_i && !r_q.err) begin
                    r_d.idle = 1'b0;
                    r_d.st   = S_FETCH;
                    r_d.widx = 2'd0;
                end else if (cur_load_i) begin
                    r_d.cur = cur_ptr_i;
                end
            end
            S_FETCH: begin
                if (mem_ack_i) begin
                    r_d.widx = r_q.widx + 2'd1;
                    case (r_q.widx)
                        2'd0: r_d.nxt  = mem_rdata_i[AW-1:0];
                        2'd1: r_d.bptr = mem_rdata_i[AW-1:0];
                        2'd2: r_d.ctrl = mem_rdata_i;
                        default: begin
                            if (mem_rdata_i[STAT_DONE_BIT]) begin
                                r_d.idle = 1'b1;
                                r_d.st   = S_IDLE;
                            end else if (over) begin
                                r_d.err  = 1'b1;
                                r_d.idle = 1'b1;
                                r_d.st   = S_IDLE;
                            end else begin
                                r_d.pos = pos_nxt;
                                if (sof) begin
                                    r_d.st   = S_APP;
                                    r_d.aidx = '0;
                                end else begin
                                    go_data = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            S_APP: begin
                if (mem_ack_i) begin
                    r_d.app[r_q.aidx] = mem_rdata_i;
                    if (r_q.aidx == AIDX_W'(APP_WORDS - 1)) go_data = 1'b1;
                    else r_d.aidx = r_q.aidx + 1'b1;
                end
            end
            S_RD: begin
                if (mem_ack_i) begin
                    r_d.beat = mem_rdata_i;
                    r_d.st   = S_BEAT;
                end
            end
            S_BEAT: begin
                if (m_tready_i) begin
                    r_d.rem  = r_q.rem - LEN_W'(step);
                    r_d.bptr = r_q.bptr + AW'(4);
                    r_d.st   = (r_q.rem == LEN_W'(step)) ? S_WB : S_RD;
                end
            end
            S_WB: begin
                if (mem_ack_i) begin
                    r_d.done = eof;
                    if (eof) r_d.pos = '0;
                    r_d.cur = r_q.nxt;
                    if (r_q.cur == r_q.tail) begin
                        r_d.idle = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st   = S_FETCH;
                        r_d.widx = 2'd0;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (go_data) begin
            r_d.rem = len;
            if (len == '0) r_d.st = eof ? S_BEAT : S_WB;
            else           r_d.st = S_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.idle <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_wdata_o                = '0;
        mem_wdata_o[LEN_W-1:0]     = len;
        mem_wdata_o[STAT_DONE_BIT] = 1'b1;
        case (r_q.st)
            S_FETCH: mem_addr_o = r_q.cur + AW'(fetch_off);
            S_APP:   mem_addr_o = r_q.cur + AW'(OFF_APP) + AW'({r_q.aidx, 2'b00});
            S_RD:    mem_addr_o = r_q.bptr;
            S_WB:    mem_addr_o = r_q.cur + AW'(OFF_STAT);
            default: mem_addr_o = '0;
        endcase
    end

    assign mem_req_o  = (r_q.st == S_FETCH) || (r_q.st == S_APP) ||
                        (r_q.st == S_RD) || (r_q.st == S_WB);
    assign mem_we_o   = (r_q.st == S_WB);
    assign m_tvalid_o = (r_q.st == S_BEAT);
    assign m_tdata_o  = r_q.beat;
    assign m_tkeep_o  = keep;
    assign m_tlast_o  = last;
    assign idle_o     = r_q.idle;
    assign err_o      = r_q.err;
    assign done_o     = r_q.done;
    assign cur_ptr_o  = r_q.cur;
    assign app_o      = r_q.app;

    p_beat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) &&
        $stable(m_tkeep_o) && $stable(m_tlast_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o && !m_tvalid_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !mem_req_o && !m_tvalid_o);

    p_empty_beat_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid_o && (m_tkeep_o == 4'h0) |-> m_tlast_o);
endmodule

// File: tb/sg_mm2s_engine_tb.sv
module sg_mm2s_engine_tb;
    localparam int AW = 32;
    localparam int APPW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, cur_load = 1'b0, tail_wr = 1'b0;
    logic [AW-1:0] cur_ptr = '0, tail_ptr = '0;
    logic idle, err, done;
    logic [AW-1:0] cur_o;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic tvalid, tready, tlast;
    logic [31:0] tdata;
    logic [3:0] tkeep;
    logic [APPW*32-1:0] app;

    int vectors = 0;
    int miscompares = 0;
    int done_cnt = 0;
    logic [36:0] expq[$];
    logic [31:0] mem [0:2047];
    logic [7:0] lfsr = 8'h5B;

    always #10 clk = ~clk;

    sg_mm2s_engine u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cur_load_i(cur_load), .cur_ptr_i(cur_ptr),
        .tail_wr_i(tail_wr), .tail_ptr_i(tail_ptr), .idle_o(idle), .err_o(err), .done_o(done),
        .cur_ptr_o(cur_o), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata), .m_tkeep_o(tkeep),
        .m_tlast_o(tlast), .app_o(app)
    );

    // memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[12:2]];
        end else mem_ack <= 1'b0;
    end

    // sink backpressure pattern
    initial tready = 1'b1;
    always @(posedge clk) begin
        #1;
        lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tready = lfsr[0] | lfsr[1];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare each accepted beat with the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && tvalid && tready) begin
            if (expq.size() == 0) begin
                chk("R5 unexpected beat", {tdata[27:0], tkeep}, 32'hFFFF_FFFF);
            end else begin
                logic [36:0] e;
                logic [31:0] m;
                e = expq.pop_front();
                for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{e[1+b]}};
                chk("R5 beat data", tdata & m, e[36:5] & m);
                chk("R5 beat keep", {28'h0, tkeep}, {28'h0, e[4:1]});
                chk("R6 beat last", {31'h0, tlast}, {31'h0, e[0]});
            end
        end
    end

    function automatic logic [31:0] app_word(input logic [31:0] a, input int k);
        return 32'hA000_0000 | (a << 8) | k;
    endfunction

    task automatic wr_desc(input logic [31:0] a, nxt, bufa, ctrl, stat);
        mem[a[12:2]]     = nxt;
        mem[a[12:2] + 1] = 32'h0;
        mem[a[12:2] + 2] = bufa;
        mem[a[12:2] + 3] = 32'h0;
        mem[a[12:2] + 6] = ctrl;
        mem[a[12:2] + 7] = stat;
        for (int k = 0; k < APPW; k++) mem[a[12:2] + 8 + k] = app_word(a, k);
    endtask

    task automatic push_desc(input logic [31:0] bufa, input int len, input logic eof);
        int n;
        n = (len + 3) / 4;
        if (len == 0 && eof) expq.push_back({32'h0, 4'h0, 1'b1});
        for (int i = 0; i < n; i++) begin
            int r;
            logic [3:0] k;
            logic [10:0] idx;
            r = len - 4 * i;
            k = (r >= 4) ? 4'hF : 4'((1 << r) - 1);
            idx = 11'((bufa >> 2) + i);
            expq.push_back({mem[idx], k, eof && (i == n - 1)});
        end
    endtask

    task automatic walk(input logic [31:0] cur, tail, input logic r);
        @(negedge clk); cur_load = 1'b1; cur_ptr = cur;
        @(negedge clk); cur_load = 1'b0; tail_wr = 1'b1; tail_ptr = tail; run = r;
        @(negedge clk); tail_wr = 1'b0;
        repeat (3) @(negedge clk);
        while (!idle) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_app(input string req, input logic [31:0] a);
        for (int k = 0; k < APPW; k++) chk(req, app[32*k +: 32], app_word(a, k));
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [31:0] SOF = 32'h0800_0000;
    localparam logic [31:0] EOF = 32'h0400_0000;
    localparam logic [31:0] CMP = 32'h8000_0000;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle", {31'h0, idle}, 32'h1);
        chk("R1 err", {31'h0, err}, 32'h0);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 tvalid", {31'h0, tvalid}, 32'h0);
        chk("R1 cur", cur_o, 32'h0);

        // single packet, partial last word (R3 R5 R6 R7 R8 R9 R10)
        wr_desc(32'h100, 32'h140, 32'h800, SOF | EOF | 32'd10, 32'h0);
        push_desc(32'h800, 10, 1'b1);
        walk(32'h100, 32'h100, 1'b1);
        chk("R5 queue drained", expq.size(), 0);
        chk("R7 status", mem[32'h11C >> 2], CMP | 32'd10);
        chk("R9 cur", cur_o, 32'h140);
        chk("R8 done count", done_cnt, 1);
        chk_app("R10 app words", 32'h100);

        // three-descriptor chain ending at tail (R5 R9)
        wr_desc(32'h140, 32'h180, 32'h900, SOF | 32'd8, 32'h0);
        wr_desc(32'h180, 32'h1C0, 32'h940, 32'd5, 32'h0);
        wr_desc(32'h1C0, 32'h200, 32'h980, EOF | 32'd4, 32'h0);
        push_desc(32'h900, 8, 1'b0);
        push_desc(32'h940, 5, 1'b0);
        push_desc(32'h980, 4, 1'b1);
        walk(32'h140, 32'h1C0, 1'b1);
        chk("R5 chain drained", expq.size(), 0);
        chk("R7 status mid", mem[32'h19C >> 2], CMP | 32'd5);
        chk("R7 status end", mem[32'h1DC >> 2], CMP | 32'd4);
        chk("R9 cur after tail", cur_o, 32'h200);
        chk("R8 done count chain", done_cnt, 2);

        // stop at an already complete descriptor (R4)
        wr_desc(32'h200, 32'h240, 32'hA00, SOF | EOF | 32'd6, 32'h0);
        wr_desc(32'h240, 32'h280, 32'hA40, SOF | EOF | 32'd4, CMP);
        push_desc(32'hA00, 6, 1'b1);
        walk(32'h200, 32'h280, 1'b1);
        chk("R4 queue drained", expq.size(), 0);
        chk("R4 cur stays", cur_o, 32'h240);
        chk("R4 status untouched", mem[32'h25C >> 2], CMP);
        chk("R7 status before stop", mem[32'h21C >> 2], CMP | 32'd6);
        chk("R8 done count", done_cnt, 3);
        chk_app("R10 app words kept", 32'h200);

        // tail strobe with run low (R2)
        wr_desc(32'h240, 32'h280, 32'hA40, SOF | EOF | 32'd4, 32'h0);
        walk(32'h240, 32'h240, 1'b0);
        repeat (20) @(negedge clk);
        chk("R2 stays idle", {31'h0, idle}, 32'h1);
        chk("R2 no writeback", mem[32'h25C >> 2], 32'h0);
        chk("R2 cur unchanged", cur_o, 32'h240);

        // zero-length end-of-frame descriptor (R6)
        wr_desc(32'h280, 32'h2C0, 32'hB00, SOF | 32'd4, 32'h0);
        wr_desc(32'h2C0, 32'h300, 32'hB40, EOF, 32'h0);
        push_desc(32'hB00, 4, 1'b0);
        push_desc(32'hB40, 0, 1'b1);
        walk(32'h280, 32'h2C0, 1'b1);
        chk("R6 queue drained", expq.size(), 0);
        chk("R7 zero-length status", mem[32'h2DC >> 2], CMP);
        chk("R8 done count", done_cnt, 4);

        // packet of exactly the limit (R11)
        wr_desc(32'h300, 32'h340, 32'h1000, SOF | EOF | 32'd16384, 32'h0);
        push_desc(32'h1000, 16384, 1'b1);
        walk(32'h300, 32'h300, 1'b1);
        chk("R11 exact limit drained", expq.size(), 0);
        chk("R11 exact limit no error", {31'h0, err}, 32'h0);
        chk("R7 full status", mem[32'h31C >> 2], CMP | 32'd16384);

        // packet growing past the limit across descriptors (R11)
        wr_desc(32'h340, 32'h380, 32'hC00, SOF | 32'd8, 32'h0);
        wr_desc(32'h380, 32'h3C0, 32'hC40, EOF | 32'd16380, 32'h0);
        push_desc(32'hC00, 8, 1'b0);
        walk(32'h340, 32'h380, 1'b1);
        chk("R11 error set", {31'h0, err}, 32'h1);
        chk("R11 no data", expq.size(), 0);
        chk("R11 no writeback", mem[32'h39C >> 2], 32'h0);
        chk("R11 cur stays", cur_o, 32'h380);
        chk("R11 no done", done_cnt, 5);
        walk(32'h380, 32'h380, 1'b1);
        repeat (20) @(negedge clk);
        chk("R11 sticky error", {31'h0, err}, 32'h1);
        chk("R11 restart blocked", mem[32'h39C >> 2], 32'h0);
        chk("R11 idle after block", {31'h0, idle}, 32'h1);
        finish_run();
    end
endmodule